// File: doc/BRIEF.md
# USB Host Controller Functional-State and Command Registers

This block is the register unit that holds the host controller's functional state, its command bits and its scheduling-overrun bookkeeping. Host software reaches it through a register port. Each access carries an 8-bit code, and reads and writes use different codes. When the host moves the controller into the operational state, the block waits a programmable number of millisecond ticks before it enables start-of-frame generation. On each end of frame it checks whether the periodic list finished. If it did not, it counts a scheduling overrun and raises an interrupt-status flag.

Three event types change state apart from host writes. A hardware reset clears everything and requests reset signalling on the downstream ports. A software reset sends only the functional state back to RESET. When resume signalling is detected downstream, a suspended controller moves to RESUME. Elsewhere in the controller, logic clears the command bits through a one-cycle acknowledge vector.

Top module: `usb_hc_state_regs`

## Requirements
- R1: The functional state sits in bits 7:6 of the control register, encoded 00 RESET, 01 RESUME, 10 OPERATIONAL, 11 SUSPEND. The register is read with code 0x01 and written with code 0x81. Every other bit reads 0 and ignores writes, and any code that is not decoded reads 0.
- R2: After the state enters OPERATIONAL from another state, `sof_en_o` rises on the DELAY_TICKS-th `ms_tick_i` pulse after the write (default 1). A tick in the same cycle as the write does not count, and writing OPERATIONAL again while already OPERATIONAL changes nothing.
- R3: `sof_en_o` falls in the same cycle the state leaves OPERATIONAL. Leaving before the delay expires cancels the pending start.
- R4: The interrupt-status register (read code 0x03, write code 0x83) holds a start-of-frame flag in bit 2. The flag sets when SOF generation begins and is visible on `sof_status_o`. Writing 1 to bit 2 clears it, and writing 0 leaves it unchanged.
- R5: In SUSPEND, a `resume_det_i` pulse moves the state to RESUME. In any other state the pulse is ignored.
- R6: `sw_reset_i` forces the state to RESET and drops `sof_en_o`. The command bits and the overrun count are kept.
- R7: `hw_reset_i` forces the state to RESET and clears the command bits, the overrun count and both interrupt flags. `port_reset_o` is high for exactly the cycle after the reset cycle.
- R8: The command register is read with code 0x02 and written with code 0x82. Command bits CMD_W-1:0 (default 4) are write-one-to-set, and bits written as 0 stay as they were. Bits 17:16 of this register cannot be written.
- R9: A 1 in `cmd_ack_i` clears the matching command bit. A host write of 1 to the same bit in the same cycle wins, so the bit stays set.
- R10: An `eof_i` pulse with no `periodic_done_i` since the previous end of frame (same cycle included) increments the 2-bit overrun count in bits 17:16 of the command register. The count wraps from 3 to 0.
- R11: A scheduling overrun sets bit 0 of the interrupt-status register, which is also driven on `sched_overrun_o`. Writing 1 to bit 0 clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| cmd_valid_i | input | 1 | Register access strobe (writes take effect only with it) |
| cmd_code_i | input | 8 | Register access code |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the code on `cmd_code_i` (combinational) |
| cmd_ack_i | input | CMD_W | One-cycle clear of command bits |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| eof_i | input | 1 | End-of-frame pulse |
| periodic_done_i | input | 1 | Periodic list completed in this frame |
| resume_det_i | input | 1 | Downstream resume signalling detected |
| sw_reset_i | input | 1 | Software reset pulse |
| hw_reset_i | input | 1 | Hardware reset pulse |
| sof_en_o | output | 1 | Start-of-frame generation enabled |
| sched_overrun_o | output | 1 | Scheduling-overrun interrupt-status bit |
| sof_status_o | output | 1 | Start-of-frame interrupt-status bit |
| port_reset_o | output | 1 | Request for reset signalling toward downstream ports |

## Verification
The start-of-frame delay is exercised three ways:
- a clean entry followed by one tick;
- a repeated OPERATIONAL write once SOF is running, which must not restart anything;
- an exit before the tick, which must leave both SOF enable and its status flag at 0.

The overrun counter receives four patterns:
- an end of frame alone;
- completion in an earlier cycle, then end of frame;
- completion in the same cycle as end of frame;
- a run of bare end-of-frame pulses long enough to wrap.

These patterns separate correct frame-completion tracking from a counter that ignores or mistimes the completion input. Command bits are driven with writes of 0, writes to the read-only count bits, and an acknowledge that collides with a write, which tells write-one-to-set apart from plain overwriting and checks which side wins the collision.

// File: rtl/hc_regs_pkg.sv
package hc_regs_pkg;
    typedef enum logic [1:0] {
        FS_RESET   = 2'b00,
        FS_RESUME  = 2'b01,
        FS_OPER    = 2'b10,
        FS_SUSPEND = 2'b11
    } fstate_e;

    localparam logic [7:0] CODE_CTRL_RD = 8'h01;
    localparam logic [7:0] CODE_CTRL_WR = 8'h81;
    localparam logic [7:0] CODE_CMD_RD  = 8'h02;
    localparam logic [7:0] CODE_CMD_WR  = 8'h82;
    localparam logic [7:0] CODE_INT_RD  = 8'h03;
    localparam logic [7:0] CODE_INT_WR  = 8'h83;

    localparam int FS_LSB     = 6;
    localparam int SOC_LSB    = 16;
    localparam int INT_SO_BIT = 0;
    localparam int INT_SF_BIT = 2;
endpackage

// File: rtl/hc_func_state.sv
module hc_func_state
    import hc_regs_pkg::*;
#(
    parameter int DELAY_TICKS = 1
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    hw_reset_i,
    input  logic    sw_reset_i,
    input  logic    wr_i,
    input  fstate_e wr_state_i,
    input  logic    resume_i,
    input  logic    ms_tick_i,
    output fstate_e state_o,
    output logic    sof_en_o,
    output logic    sof_start_o,
    output logic    port_reset_o
);
    localparam int TICK_W = $clog2(DELAY_TICKS + 1);
    localparam logic [TICK_W-1:0] LAST_CNT = TICK_W'(DELAY_TICKS - 1);

    typedef struct packed {
        fstate_e           state;
        logic              pending;
        logic [TICK_W-1:0] cnt;
        logic              sof_en;
        logic              port_rst;
    } fs_regs_t;

    fs_regs_t q, d;
    logic     start;

    always_comb begin
        d          = q;
        d.port_rst = 1'b0;
        start      = 1'b0;
        if (hw_reset_i) begin
            d.state    = FS_RESET;
            d.port_rst = 1'b1;
        end else if (sw_reset_i) begin
            d.state = FS_RESET;
        end else if (wr_i) begin
            d.state = wr_state_i;
        end else if (resume_i && q.state == FS_SUSPEND) begin
            d.state = FS_RESUME;
        end

        if (d.state != FS_OPER) begin
            d.pending = 1'b0;
            d.cnt     = '0;
            d.sof_en  = 1'b0;
        end else if (q.state != FS_OPER) begin
            d.pending = 1'b1;
            d.cnt     = '0;
        end else if (q.pending && ms_tick_i) begin
            if (q.cnt == LAST_CNT) begin
                d.pending = 1'b0;
                d.sof_en  = 1'b1;
                start     = 1'b1;
            end else begin
                d.cnt = q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: FS_RESET, pending: 1'b0, cnt: '0, sof_en: 1'b0, port_rst: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign state_o      = q.state;
    assign sof_en_o     = q.sof_en;
    assign sof_start_o  = start;
    assign port_reset_o = q.port_rst;
endmodule

// File: rtl/hc_cmd_status.sv
module hc_cmd_status #(
    parameter int CMD_W = 4,
    parameter int SOC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hw_reset_i,
    input  logic             wr_i,
    input  logic [CMD_W-1:0] set_bits_i,
    input  logic [CMD_W-1:0] ack_i,
    input  logic             eof_i,
    input  logic             periodic_done_i,
    output logic [CMD_W-1:0] cmd_o,
    output logic [SOC_W-1:0] soc_o,
    output logic             overrun_o
);
    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [SOC_W-1:0] soc;
        logic             done_seen;
    } cs_regs_t;

    cs_regs_t q, d;
    logic     ovr;

    always_comb begin
        d     = q;
        d.cmd = (q.cmd & ~ack_i) | (wr_i ? set_bits_i : '0);
        ovr   = eof_i && !(q.done_seen || periodic_done_i);
        if (eof_i) begin
            d.done_seen = 1'b0;
        end else if (periodic_done_i) begin
            d.done_seen = 1'b1;
        end
        if (ovr) begin
            d.soc = q.soc + 1'b1;
        end
        if (hw_reset_i) begin
            d   = '0;
            ovr = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_o     = q.cmd;
    assign soc_o     = q.soc;
    assign overrun_o = ovr;
endmodule

// File: rtl/hc_int_status.sv
module hc_int_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hw_reset_i,
    input  logic so_set_i,
    input  logic sf_set_i,
    input  logic so_clr_i,
    input  logic sf_clr_i,
    output logic so_o,
    output logic sf_o
);
    typedef struct packed {
        logic so;
        logic sf;
    } is_regs_t;

    is_regs_t q, d;

    always_comb begin
        d.so = (q.so && !so_clr_i) || so_set_i;
        d.sf = (q.sf && !sf_clr_i) || sf_set_i;
        if (hw_reset_i) begin
            d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign so_o = q.so;
    assign sf_o = q.sf;
endmodule

// File: rtl/usb_hc_state_regs.sv
module usb_hc_state_regs
    import hc_regs_pkg::*;
#(
    parameter int CMD_W       = 4,
    parameter int DELAY_TICKS = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid_i,
    input  logic [7:0]       cmd_code_i,
    input  logic [31:0]      wdata_i,
    output logic [31:0]      rdata_o,
    input  logic [CMD_W-1:0] cmd_ack_i,
    input  logic             ms_tick_i,
    input  logic             eof_i,
    input  logic             periodic_done_i,
    input  logic             resume_det_i,
    input  logic             sw_reset_i,
    input  logic             hw_reset_i,
    output logic             sof_en_o,
    output logic             sched_overrun_o,
    output logic             sof_status_o,
    output logic             port_reset_o
);
    localparam int SOC_W = 2;

    logic             wr_ctrl, wr_cmd, wr_int;
    fstate_e          fs;
    logic [1:0]       fstate;
    logic             sof_start;
    logic [CMD_W-1:0] cmd_bits;
    logic [SOC_W-1:0] soc;
    logic             overrun;
    logic             wdata_unused;

    assign wr_ctrl      = cmd_valid_i && (cmd_code_i == CODE_CTRL_WR);
    assign wr_cmd       = cmd_valid_i && (cmd_code_i == CODE_CMD_WR);
    assign wr_int       = cmd_valid_i && (cmd_code_i == CODE_INT_WR);
    assign wdata_unused = ^wdata_i;

    hc_func_state #(.DELAY_TICKS(DELAY_TICKS)) i_fs (
        .clk          (clk),
        .rst_n        (rst_n),
        .hw_reset_i   (hw_reset_i),
        .sw_reset_i   (sw_reset_i),
        .wr_i         (wr_ctrl),
        .wr_state_i   (fstate_e'(wdata_i[FS_LSB +: 2])),
        .resume_i     (resume_det_i),
        .ms_tick_i    (ms_tick_i),
        .state_o      (fs),
        .sof_en_o     (sof_en_o),
        .sof_start_o  (sof_start),
        .port_reset_o (port_reset_o)
    );

    hc_cmd_status #(.CMD_W(CMD_W), .SOC_W(SOC_W)) i_cs (
        .clk             (clk),
        .rst_n           (rst_n),
        .hw_reset_i      (hw_reset_i),
        .wr_i            (wr_cmd),
        .set_bits_i      (wdata_i[CMD_W-1:0]),
        .ack_i           (cmd_ack_i),
        .eof_i           (eof_i),
        .periodic_done_i (periodic_done_i),
        .cmd_o           (cmd_bits),
        .soc_o           (soc),
        .overrun_o       (overrun)
    );

    hc_int_status i_is (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_reset_i (hw_reset_i),
        .so_set_i   (overrun),
        .sf_set_i   (sof_start),
        .so_clr_i   (wr_int && wdata_i[INT_SO_BIT]),
        .sf_clr_i   (wr_int && wdata_i[INT_SF_BIT]),
        .so_o       (sched_overrun_o),
        .sf_o       (sof_status_o)
    );

    assign fstate = fs;

    always_comb begin
        rdata_o = '0;
        case (cmd_code_i)
            CODE_CTRL_RD: rdata_o[FS_LSB +: 2] = fstate;
            CODE_CMD_RD: begin
                rdata_o[CMD_W-1:0]           = cmd_bits;
                rdata_o[SOC_LSB +: SOC_W]    = soc;
            end
            CODE_INT_RD: begin
                rdata_o[INT_SO_BIT] = sched_overrun_o;
                rdata_o[INT_SF_BIT] = sof_status_o;
            end
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/hc_regs_chk.sv
module hc_regs_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       hw_reset_i,
    input logic       sw_reset_i,
    input logic       ms_tick_i,
    input logic       eof_i,
    input logic [1:0] fstate,
    input logic [1:0] soc,
    input logic       sof_en_o,
    input logic       sched_overrun_o,
    input logic       port_reset_o
);
    assert_reset_state_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_reset_i || sw_reset_i) |=> (fstate == 2'b00));

    assert_sof_only_oper_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sof_en_o |-> (fstate == 2'b10));

    assert_sof_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sof_en_o) |-> $past(ms_tick_i));

    assert_overrun_on_eof_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sched_overrun_o) |-> $past(eof_i));

    assert_count_moves_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(soc) |-> ($past(eof_i) || $past(hw_reset_i)));

    assert_port_reset_R7: assert property (@(posedge clk) disable iff (!rst_n)
        port_reset_o |-> $past(hw_reset_i));
endmodule

bind usb_hc_state_regs hc_regs_chk i_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .hw_reset_i      (hw_reset_i),
    .sw_reset_i      (sw_reset_i),
    .ms_tick_i       (ms_tick_i),
    .eof_i           (eof_i),
    .fstate          (fstate),
    .soc             (soc),
    .sof_en_o        (sof_en_o),
    .sched_overrun_o (sched_overrun_o),
    .port_reset_o    (port_reset_o)
);

// File: tb/test_usb_hc_state_regs.sv
module test_usb_hc_state_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_code = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  cmd_ack = '0;
    logic        ms_tick = 1'b0, eof = 1'b0, pdone = 1'b0, resume = 1'b0;
    logic        sw_rst = 1'b0, hw_rst = 1'b0;
    logic        sof_en, so_flag, sf_flag, port_rst;

    int applied = 0;
    int failed  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    usb_hc_state_regs i_usb_hc_state_regs (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid), .cmd_code_i(cmd_code),
        .wdata_i(wdata), .rdata_o(rdata), .cmd_ack_i(cmd_ack), .ms_tick_i(ms_tick),
        .eof_i(eof), .periodic_done_i(pdone), .resume_det_i(resume),
        .sw_reset_i(sw_rst), .hw_reset_i(hw_rst), .sof_en_o(sof_en),
        .sched_overrun_o(so_flag), .sof_status_o(sf_flag), .port_reset_o(port_rst)
    );

    // {write, code, data, expected read}
    localparam int NV = 14;
    localparam logic [72:0] VEC [NV] = '{
        {1'b0, 8'h01, 32'h0,         32'h0},
        {1'b0, 8'h02, 32'h0,         32'h0},
        {1'b1, 8'h82, 32'h0003_0005, 32'h0},
        {1'b0, 8'h02, 32'h0,         32'h5},
        {1'b1, 8'h82, 32'h0000_0002, 32'h0},
        {1'b0, 8'h02, 32'h0,         32'h7},
        {1'b1, 8'h82, 32'h0,         32'h0},
        {1'b0, 8'h02, 32'h0,         32'h7},
        {1'b1, 8'h81, 32'hFFFF_FF7F, 32'h0},
        {1'b0, 8'h01, 32'h0,         32'h40},
        {1'b1, 8'h81, 32'h0000_00C0, 32'h0},
        {1'b0, 8'h01, 32'h0,         32'hC0},
        {1'b0, 8'h55, 32'h0,         32'h0},
        {1'b0, 8'h03, 32'h0,         32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        applied++;
        if (act !== exp) begin
            failed++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] code, input logic [31:0] data);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_code = code; wdata = data;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_code = 8'h00; wdata = '0;
    endtask

    task automatic rd(input string tag, input logic [7:0] code, input logic [31:0] mask,
                      input logic [31:0] exp);
        cmd_code = code;
        #1;
        check(tag, rdata & mask, exp);
        cmd_code = 8'h00;
    endtask

    task automatic tick();
        @(negedge clk); ms_tick = 1'b1;
        @(negedge clk); ms_tick = 1'b0;
    endtask

    task automatic eof_pulse(input logic with_done);
        @(negedge clk); eof = 1'b1; pdone = with_done;
        @(negedge clk); eof = 1'b0; pdone = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            failed++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R7 reset sof_en", {31'b0, sof_en}, 32'h0);
        check("R7 reset overrun", {31'b0, so_flag}, 32'h0);
        check("R7 reset port_reset", {31'b0, port_rst}, 32'h0);

        // R1 / R8 table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) begin
                wr(VEC[i][71:64], VEC[i][63:32]);
            end else begin
                rd((VEC[i][65:64] == 2'b10) ? "R8 table" : "R1 table",
                   VEC[i][71:64], 32'hFFFF_FFFF, VEC[i][31:0]);
            end
        end

        // R9: ack clears, simultaneous write wins
        @(negedge clk); cmd_ack = 4'b0001;
        @(negedge clk); cmd_ack = 4'b0000;
        rd("R9 ack clear", 8'h02, 32'hF, 32'h6);
        @(negedge clk); cmd_ack = 4'b0010; cmd_valid = 1'b1; cmd_code = 8'h82; wdata = 32'h2;
        @(negedge clk); cmd_ack = 4'b0000; cmd_valid = 1'b0; cmd_code = 8'h00; wdata = '0;
        rd("R9 write wins", 8'h02, 32'hF, 32'h6);

        // R5: resume in SUSPEND only
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        rd("R5 suspend->resume", 8'h01, 32'hFFFF_FFFF, 32'h40);
        wr(8'h81, 32'h0);
        @(negedge clk); resume = 1'b1;
        @(negedge clk); resume = 1'b0;
        rd("R5 ignored in reset", 8'h01, 32'hFFFF_FFFF, 32'h0);

        // R2 / R4: delayed SOF start
        wr(8'h81, 32'h80);
        check("R2 no sof before tick", {31'b0, sof_en}, 32'h0);
        rd("R4 status clear before", 8'h03, 32'hFFFF_FFFF, 32'h0);
        tick();
        check("R2 sof after tick", {31'b0, sof_en}, 32'h1);
        rd("R4 sof status set", 8'h03, 32'hFFFF_FFFF, 32'h4);
        wr(8'h81, 32'h80);
        check("R2 rewrite oper keeps sof", {31'b0, sof_en}, 32'h1);
        wr(8'h83, 32'h0);
        rd("R4 write 0 no effect", 8'h03, 32'hFFFF_FFFF, 32'h4);
        wr(8'h83, 32'h4);
        rd("R4 write 1 clears", 8'h03, 32'hFFFF_FFFF, 32'h0);

        // R3: exit drops at once, early exit cancels
        wr(8'h81, 32'hC0);
        check("R3 exit drops sof", {31'b0, sof_en}, 32'h0);
        wr(8'h81, 32'h80);
        wr(8'h81, 32'h00);
        tick();
        check("R3 cancelled sof_en", {31'b0, sof_en}, 32'h0);
        rd("R3 cancelled status", 8'h03, 32'hFFFF_FFFF, 32'h0);

        // R10 / R11: overrun counter and flag
        eof_pulse(1'b0);
        rd("R10 count 1", 8'h02, 32'h0003_0000, 32'h0001_0000);
        check("R11 overrun out", {31'b0, so_flag}, 32'h1);
        rd("R11 overrun bit", 8'h03, 32'h1, 32'h1);
        wr(8'h83, 32'h1);
        rd("R11 w1c", 8'h03, 32'h1, 32'h0);
        @(negedge clk); pdone = 1'b1;
        @(negedge clk); pdone = 1'b0;
        eof_pulse(1'b0);
        rd("R10 done earlier", 8'h02, 32'h0003_0000, 32'h0001_0000);
        eof_pulse(1'b1);
        rd("R10 done same cycle", 8'h02, 32'h0003_0000, 32'h0001_0000);
        check("R11 no overrun flag", {31'b0, so_flag}, 32'h0);
        eof_pulse(1'b0);
        rd("R10 count 2", 8'h02, 32'h0003_0000, 32'h0002_0000);
        eof_pulse(1'b0);
        rd("R10 count 3", 8'h02, 32'h0003_0000, 32'h0003_0000);
        eof_pulse(1'b0);
        rd("R10 wrap", 8'h02, 32'h0003_0000, 32'h0);
        eof_pulse(1'b0);
        rd("R10 count after wrap", 8'h02, 32'h0003_0000, 32'h0001_0000);

        // R6: software reset
        wr(8'h81, 32'h80);
        tick();
        @(negedge clk); sw_rst = 1'b1;
        @(negedge clk); sw_rst = 1'b0;
        rd("R6 state reset", 8'h01, 32'hFFFF_FFFF, 32'h0);
        check("R6 sof dropped", {31'b0, sof_en}, 32'h0);
        rd("R6 cmd kept", 8'h02, 32'hFFFF_FFFF, 32'h0001_0006);

        // R7: hardware reset
        wr(8'h81, 32'hC0);
        @(negedge clk); hw_rst = 1'b1;
        @(negedge clk); hw_rst = 1'b0;
        check("R7 port reset pulse", {31'b0, port_rst}, 32'h1);
        @(negedge clk);
        check("R7 port reset ends", {31'b0, port_rst}, 32'h0);
        rd("R7 state", 8'h01, 32'hFFFF_FFFF, 32'h0);
        rd("R7 cmd cleared", 8'h02, 32'hFFFF_FFFF, 32'h0);
        rd("R7 int cleared", 8'h03, 32'hFFFF_FFFF, 32'h0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, failed);
        $finish;
    end
endmodule